// File: doc/BRIEF.md
# Hamming SEC-DED Memory Codec

This block protects words held in a memory with a single-error-correcting, double-error-detecting code. The encode path takes a data word and builds a codeword in which the check bits sit at the power-of-two positions and the data bits fill the other positions. It also produces one extra overall parity bit. The word to store is the codeword together with that bit.

The decode path takes a stored codeword and its overall bit as they are read back. It computes a syndrome whose value names the failing position, flips that position when the error is a single one, and flags the word as uncorrectable when two bits are bad.

Both paths are independent and have one register stage each. Each path has an enable that loads its output registers, and a valid flag that follows that enable one cycle later. The data width is a parameter. The number of check bits is derived from it as the smallest k for which 2^k is at least data width + k + 1. The default is 8 data bits, 4 check bits and 1 overall bit.

Top module: `secded_codec`

## Requirements
- R1: Codeword position p (1..CW) is bit p-1 of the word. Positions 1, 2, 4, 8, ... hold check bits. Data bit 0 goes to the lowest remaining position and the other data bits follow in ascending order. For the default width, data bit 0 is at position 3 and data bit 7 is at position 12.
- R2: Check bit at position 2^j is the XOR of all data positions whose number has bit j set. The overall bit makes the XOR of the 12 codeword bits plus itself equal to 0.
- R3: An enable sampled high updates that path's outputs at the next rising edge, and that path's valid flag goes high at the same edge. With the enable low, the path's data outputs hold their value and its valid flag is 0.
- R4: A word read back unchanged gives syndrome 0, both flags 0, and the original data.
- R5: A single flipped codeword bit at position p, data or check, gives syndrome p, the corrected data, corrected flag 1 and uncorrectable flag 0.
- R6: A flipped overall bit alone gives syndrome 0, corrected flag 1, uncorrectable flag 0, and the original data.
- R7: Two flipped bits, counting the overall bit, give a nonzero syndrome, uncorrectable flag 1, corrected flag 0, and the data bits exactly as read, with no bit flipped.
- R8: A nonzero syndrome above CW together with an overall mismatch sets the uncorrectable flag, and nothing is flipped. Example: flipping positions 1, 2 and 12 gives syndrome 15.
- R9: While reset is asserted (rst_n low), every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_en | input | 1 | Load the encode output registers |
| enc_data | input | DW | Data word to encode |
| enc_vld | output | 1 | Encode result loaded at the last edge |
| enc_word | output | CW | Codeword, bit p-1 is position p |
| enc_ovp | output | 1 | Overall parity bit of the codeword |
| dec_en | input | 1 | Load the decode output registers |
| dec_word | input | CW | Codeword as read back |
| dec_ovp | input | 1 | Overall parity bit as read back |
| dec_vld | output | 1 | Decode result loaded at the last edge |
| dec_data | output | DW | Corrected data, or the raw data bits when uncorrectable |
| dec_syn | output | PW | Syndrome, the failing position or 0 |
| dec_fixed | output | 1 | A single error was corrected |
| dec_fatal | output | 1 | The word has an error that cannot be corrected |

## Verification
The only state the block has is its two output register banks, so any internal fault shows at the ports one cycle after the enable that exercised it.

A data bit placed at the wrong position, or a wrong cover mask for one check bit, changes enc_word or enc_ovp for any data that touches that position. The same fault gives a wrong syndrome value for single flips at the affected positions.

A mistake in telling the cases apart shows as wrong flag combinations or as a bit flipped that should have been left alone. The bench therefore sweeps every single-flip position, the overall-bit flip, doubles mixed with the overall bit, and an out-of-range syndrome.

// File: rtl/secded_codec.sv
module secded_codec #(
  parameter int DW = 8,
  localparam int PW = (DW <= 1) ? 2 : (DW <= 4) ? 3 : (DW <= 11) ? 4 :
                      (DW <= 26) ? 5 : (DW <= 57) ? 6 : (DW <= 120) ? 7 : 8,
  localparam int CW = DW + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_en,
  input  logic [DW-1:0] enc_data,
  output logic          enc_vld,
  output logic [CW-1:0] enc_word,
  output logic          enc_ovp,
  input  logic          dec_en,
  input  logic [CW-1:0] dec_word,
  input  logic          dec_ovp,
  output logic          dec_vld,
  output logic [DW-1:0] dec_data,
  output logic [PW-1:0] dec_syn,
  output logic          dec_fixed,
  output logic          dec_fatal
);

  function automatic int data_pos(int i);
    int c;
    int r;
    c = 0;
    r = 0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        if (c == i) r = p;
        c++;
      end
    return r;
  endfunction

  function automatic logic [CW-1:0] cover_mask(int j);
    logic [CW-1:0] m;
    m = '0;
    for (int p = 1; p <= CW; p++) m[p-1] = ((p >> j) & 1) != 0;
    return m;
  endfunction

  logic [CW-1:0] e_data, e_cw, d_flip, d_fix;
  logic [PW-1:0] e_par, d_syn;
  logic [DW-1:0] d_out;
  logic          d_ovbad, d_single, d_fatal;

  for (genvar i = 0; i < DW; i++) begin : g_data
    localparam int P = data_pos(i);
    assign e_data[P-1] = enc_data[i];
    assign d_out[i]    = d_fix[P-1];
  end

  for (genvar j = 0; j < PW; j++) begin : g_chk
    localparam int Q = 1 << j;
    assign e_data[Q-1] = 1'b0;
    assign e_par[j]    = ^(e_data & cover_mask(j));
    assign d_syn[j]    = ^(dec_word & cover_mask(j));
  end

  always_comb begin
    e_cw = e_data;
    for (int j = 0; j < PW; j++) e_cw[(1 << j) - 1] = e_par[j];
  end

  assign d_ovbad  = ^{dec_word, dec_ovp};
  assign d_single = (d_syn != '0) && d_ovbad && (d_syn <= PW'(CW));
  assign d_fatal  = (d_syn != '0) && !d_single;
  assign d_flip   = d_single ? (CW'(1) << (d_syn - 1'b1)) : '0;
  assign d_fix    = dec_word ^ d_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_vld  <= 1'b0;
      enc_word <= '0;
      enc_ovp  <= 1'b0;
    end else begin
      enc_vld <= enc_en;
      if (enc_en) begin
        enc_word <= e_cw;
        enc_ovp  <= ^e_cw;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld   <= 1'b0;
      dec_data  <= '0;
      dec_syn   <= '0;
      dec_fixed <= 1'b0;
      dec_fatal <= 1'b0;
    end else begin
      dec_vld <= dec_en;
      if (dec_en) begin
        dec_data  <= d_out;
        dec_syn   <= d_syn;
        dec_fixed <= d_ovbad && !d_fatal;
        dec_fatal <= d_fatal;
      end
    end
  end

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
  parameter int DW = 8,
  parameter int PW = 4,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enc_en,
  input logic          enc_vld,
  input logic [CW-1:0] enc_word,
  input logic          enc_ovp,
  input logic          dec_en,
  input logic [CW-1:0] dec_word,
  input logic          dec_ovp,
  input logic          dec_vld,
  input logic [DW-1:0] dec_data,
  input logic [PW-1:0] dec_syn,
  input logic          dec_fixed,
  input logic          dec_fatal
);

  p_enc_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_en |=> enc_vld);

  p_enc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_en |=> $stable(enc_word) && $stable(enc_ovp) && !enc_vld);

  p_dec_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> dec_vld);

  p_dec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> $stable(dec_data) && $stable(dec_syn) && !dec_vld);

  p_even_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enc_vld |-> (^{enc_word, enc_ovp}) == 1'b0);

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> !(dec_fixed && dec_fatal));

  p_zero_syn_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_syn == '0) |-> !dec_fatal);

  p_even_no_fix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && (^{dec_word, dec_ovp}) == 1'b0) |=> !dec_fixed);

  p_odd_no_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && (^{dec_word, dec_ovp}) == 1'b1) |=> (dec_fixed || dec_fatal));

endmodule

bind secded_codec secded_codec_chk #(.DW(DW), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .enc_en(enc_en), .enc_vld(enc_vld), .enc_word(enc_word), .enc_ovp(enc_ovp),
  .dec_en(dec_en), .dec_word(dec_word), .dec_ovp(dec_ovp), .dec_vld(dec_vld),
  .dec_data(dec_data), .dec_syn(dec_syn), .dec_fixed(dec_fixed), .dec_fatal(dec_fatal)
);

// File: tb/secded_codec_test.sv
module secded_codec_test;
  localparam int DW = 8;
  localparam int PW = 4;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enc_en = 1'b0;
  logic [DW-1:0] enc_data = '0;
  logic          enc_vld;
  logic [CW-1:0] enc_word;
  logic          enc_ovp;
  logic          dec_en = 1'b0;
  logic [CW-1:0] dec_word = '0;
  logic          dec_ovp = 1'b0;
  logic          dec_vld;
  logic [DW-1:0] dec_data;
  logic [PW-1:0] dec_syn;
  logic          dec_fixed;
  logic          dec_fatal;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  secded_codec #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .enc_en(enc_en), .enc_data(enc_data), .enc_vld(enc_vld),
    .enc_word(enc_word), .enc_ovp(enc_ovp),
    .dec_en(dec_en), .dec_word(dec_word), .dec_ovp(dec_ovp), .dec_vld(dec_vld),
    .dec_data(dec_data), .dec_syn(dec_syn), .dec_fixed(dec_fixed), .dec_fatal(dec_fatal)
  );

  function automatic int m_pos(int i);
    int p;
    int cnt;
    p = 0;
    cnt = -1;
    while (cnt < i) begin
      p++;
      if ((p & (p - 1)) != 0) cnt++;
    end
    return p;
  endfunction

  function automatic logic [CW:0] m_encode(logic [DW-1:0] d);
    logic [CW-1:0] w;
    logic par;
    w = '0;
    for (int i = 0; i < DW; i++) w[m_pos(i) - 1] = d[i];
    for (int j = 0; j < PW; j++) begin
      par = 1'b0;
      for (int p = 1; p <= CW; p++) if (((p >> j) & 1) == 1) par = par ^ w[p-1];
      w[(1 << j) - 1] = par;
    end
    return {^w, w};
  endfunction

  function automatic logic [PW-1:0] m_syn(logic [CW-1:0] w);
    int s;
    s = 0;
    for (int p = 1; p <= CW; p++) if (w[p-1]) s = s ^ p;
    return PW'(s);
  endfunction

  function automatic logic [DW-1:0] m_extract(logic [CW-1:0] w);
    logic [DW-1:0] d;
    for (int i = 0; i < DW; i++) d[i] = w[m_pos(i) - 1];
    return d;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_enc(input logic [DW-1:0] d, input string req);
    logic [CW:0] m;
    m = m_encode(d);
    @(negedge clk);
    enc_data = d;
    enc_en = 1'b1;
    @(negedge clk);
    enc_en = 1'b0;
    check({req, " enc word"}, 64'(enc_word), 64'(m[CW-1:0]));
    check({req, " enc ovp"}, 64'(enc_ovp), 64'(m[CW]));
    check({req, " enc vld"}, 64'(enc_vld), 64'd1);
  endtask

  task automatic run_dec(input logic [CW-1:0] w, input logic o,
                         input logic [DW-1:0] ed, input logic [PW-1:0] es,
                         input logic ef, input logic ex, input string req);
    @(negedge clk);
    dec_word = w;
    dec_ovp = o;
    dec_en = 1'b1;
    @(negedge clk);
    dec_en = 1'b0;
    check({req, " data"}, 64'(dec_data), 64'(ed));
    check({req, " syn"}, 64'(dec_syn), 64'(es));
    check({req, " fixed"}, 64'(dec_fixed), 64'(ef));
    check({req, " fatal"}, 64'(dec_fatal), 64'(ex));
    check({req, " vld"}, 64'(dec_vld), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW:0] m;
    logic [CW-1:0] w;
    logic o;
    logic [DW-1:0] d;
    int a;
    int b;
    int mode;
    void'($urandom(32'd4711));

    // R9: all outputs zero while reset is held
    repeat (3) @(negedge clk);
    check("R9 reset enc", 64'({enc_vld, enc_word, enc_ovp}), 64'd0);
    check("R9 reset dec", 64'({dec_vld, dec_data, dec_syn, dec_fixed, dec_fatal}), 64'd0);
    rst_n = 1'b1;

    // R1 / R2 directed layout and parity
    run_enc(8'h00, "R1 zero");
    check("R1 zero word", 64'(enc_word), 64'h000);
    run_enc(8'h01, "R1 bit0");
    check("R1 bit0 at pos3", 64'({enc_ovp, enc_word}), 64'h1007);
    run_enc(8'h80, "R1 bit7");
    check("R2 bit7 at pos12", 64'({enc_ovp, enc_word}), 64'h1888);
    for (int n = 0; n < 150; n++) run_enc(DW'($urandom), "R2 rand");

    // R3: outputs hold and valid drops with enable low
    run_enc(8'h5A, "R3 load");
    m = m_encode(8'h5A);
    @(negedge clk);
    enc_data = 8'hC3;
    @(negedge clk);
    check("R3 enc hold", 64'(enc_word), 64'(m[CW-1:0]));
    check("R3 enc vld low", 64'(enc_vld), 64'd0);

    // R4 clean
    m = m_encode(8'hA5);
    run_dec(m[CW-1:0], m[CW], 8'hA5, 4'd0, 1'b0, 1'b0, "R4 clean");
    @(negedge clk);
    dec_word = '1;
    @(negedge clk);
    check("R3 dec hold", 64'(dec_data), 64'hA5);
    check("R3 dec vld low", 64'(dec_vld), 64'd0);

    // R5 every single position
    for (int p = 1; p <= CW; p++) begin
      w = m[CW-1:0];
      w[p-1] = ~w[p-1];
      run_dec(w, m[CW], 8'hA5, PW'(p), 1'b1, 1'b0, "R5 single");
    end

    // R6 overall bit only
    run_dec(m[CW-1:0], ~m[CW], 8'hA5, 4'd0, 1'b1, 1'b0, "R6 overall");

    // R7 double: positions 3 and 5, and position 6 with the overall bit
    w = m[CW-1:0];
    w[2] = ~w[2];
    w[4] = ~w[4];
    run_dec(w, m[CW], m_extract(w), 4'd6, 1'b0, 1'b1, "R7 double");
    w = m[CW-1:0];
    w[5] = ~w[5];
    run_dec(w, ~m[CW], m_extract(w), 4'd6, 1'b0, 1'b1, "R7 double ovp");

    // R8 syndrome 15 out of range
    w = m[CW-1:0];
    w[0] = ~w[0];
    w[1] = ~w[1];
    w[11] = ~w[11];
    run_dec(w, m[CW], 8'hA5 ^ 8'h80, 4'd15, 1'b0, 1'b1, "R8 out of range");

    // random mix of R4..R7
    for (int n = 0; n < 300; n++) begin
      d = DW'($urandom);
      m = m_encode(d);
      w = m[CW-1:0];
      o = m[CW];
      mode = int'($urandom % 3);
      a = int'($urandom % (CW + 1));
      b = (a + 1 + int'($urandom % CW)) % (CW + 1);
      if (mode == 0) begin
        run_dec(w, o, d, 4'd0, 1'b0, 1'b0, "R4 rand");
      end else if (mode == 1) begin
        if (a == CW) run_dec(w, ~o, d, 4'd0, 1'b1, 1'b0, "R6 rand");
        else begin
          w[a] = ~w[a];
          run_dec(w, o, d, PW'(a + 1), 1'b1, 1'b0, "R5 rand");
        end
      end else begin
        if (a == CW) o = ~o; else w[a] = ~w[a];
        if (b == CW) o = ~o; else w[b] = ~w[b];
        run_dec(w, o, m_extract(w), m_syn(w), 1'b0, 1'b1, "R7 rand");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule